// File: doc/BRIEF.md
# Watch Stepper Motor Pulse Generator

This block drives the two coils of a two-terminal analog watch stepper motor. It runs on the 32.768 kHz timebase, where one clock is one oscillator period. It issues one drive pulse at the start of every step cycle. Successive pulses swap which output is high, so the rotor turns the same way on every step. The pulse width and the cycle length arrive as input ports, so a fuse or non-volatile store outside the block can trim them.

A two-bit battery-condition input sets the shape of each pulse:

- **Fresh lithium cell:** the pulse is chopped at three quarters duty.
- **Mid-life cell:** the pulse is driven solid.
- **Exhausted cell:** the pulse is driven solid and grouped into a burst of four pulses. The burst comes only on every fourth cycle, which tells the wearer that the cell is exhausted.

A halt input tri-states both coil outputs, for example while the crown is pulled. A fast input shortens the cycle to a fixed test length so that production test can run quickly.

Top module: `stepper_pulse_gen`

## Requirements
- R1: While reset is high, both coil outputs are low and the enable is high. The first pulse after reset is released drives `m1_o` high. It starts on the first clock edge at which reset is low.
- R2: Each completed pulse reverses the polarity of the next one. A pulse with polarity A drives `m1_o` and holds `m2_o` low. Polarity B does the reverse.
- R3: Each step cycle lasts `cycle_len_i` clocks. A pulse occupies the first `pulse_width_i` clocks of its cycle. A width of 0 is treated as 1, and the cycle length is sampled on every clock.
- R4: Mode code 0 (lithium) chops the pulse. Counted from the first clock of each pulse, the phase runs 0 to 7 and repeats. The output is on at phases 0 to 5 and off at phases 6 and 7.
- R5: Mode code 1 (silver-oxide) and the unused code 3 give a solid pulse for its full width.
- R6: Mode code 2 (end of life) gives a solid pulse. On the cycle where the cycle counter is a multiple of four, the block emits four pulses, each of width W and separated by gaps of W clocks. In the other three cycles it emits no pulse. That counter is cleared by reset and by halt.
- R7: While `stop_i` is high, `drv_en_o` is low and both coil data outputs are low. On release, a new cycle begins at once. The polarity sequence is kept, and a pulse cut short by the halt does not count as completed.
- R8: While `fast_i` is high, the cycle length is FAST_CYC clocks (1024 by default) and `cycle_len_i` is ignored.
- R9: The mode and the width are captured at the start of each cycle. A change to either takes effect only from the next cycle.
- R10: The two coil outputs are never high together, and both are low outside pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz timebase clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_i | input | 1 | Halt: tri-state coils, clear cycle timing |
| fast_i | input | 1 | Force test cycle length FAST_CYC |
| batt_mode_i | input | 2 | 0 lithium, 1 silver-oxide, 2 end of life, 3 as 1 |
| pulse_width_i | input | PW_W | Pulse width in clocks |
| cycle_len_i | input | CYC_W | Step cycle length in clocks |
| drv_en_o | output | 1 | Coil output enable; low means high impedance |
| m1_o | output | 1 | Coil terminal 1 drive level |
| m2_o | output | 1 | Coil terminal 2 drive level |

## Verification
The assertions assume that a pulse never runs past the end of its cycle. In end-of-life mode, eight widths must fit inside one cycle; in the other modes, one width must fit. The stimulus keeps every width and cycle-length pair well inside these limits, and it changes the fast setting only while the cycle counter is below the new length. The bench changes inputs only between clock edges. It places mode changes, width changes and halts at chosen cycle positions: mid-pulse, in the idle gap, and during an end-of-life burst. A behavioural model built from cycle positions then predicts every output on every clock.

// File: rtl/stepdrv_pkg.sv
package stepdrv_pkg;

    typedef enum logic [1:0] {
        BATT_LITH   = 2'd0,
        BATT_SILVER = 2'd1,
        BATT_EOL    = 2'd2,
        BATT_SPARE  = 2'd3
    } batt_e;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_ON   = 2'd1,
        SEQ_GAP  = 2'd2
    } seq_e;

    localparam int CHOP_PERIOD = 8;
    localparam int CHOP_ON     = 6;
    localparam int CHOP_PH_W   = $clog2(CHOP_PERIOD);
    localparam int BURST_LEN   = 4;
    localparam int BURST_CNT_W = $clog2(BURST_LEN);
    localparam int BURST_EVERY = 4;
    localparam int SLOT_W      = $clog2(BURST_EVERY);

    typedef struct packed {
        logic en;
        logic m1;
        logic m2;
    } drive_t;

    // Gate for the coil drive at a given chop phase within a pulse.
    function automatic logic chop_gate(input batt_e mode, input logic [CHOP_PH_W-1:0] phase);
        return (mode != BATT_LITH) || (phase < CHOP_PH_W'(CHOP_ON));
    endfunction

endpackage

// File: rtl/stepdrv_timer.sv
module stepdrv_timer #(
    parameter int CYC_W    = 18,
    parameter int FAST_CYC = 1024,
    parameter int SLOT_W   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              halt,
    input  logic              fast,
    input  logic [CYC_W-1:0]  cycle_len,
    output logic [SLOT_W-1:0] slot,
    output logic              cycle_start
);
    localparam logic [CYC_W-1:0] FAST_LAST = CYC_W'(FAST_CYC - 1);

    logic [CYC_W-1:0] cyc_cnt;
    logic [CYC_W-1:0] last;

    always_comb begin
        if (fast)                  last = FAST_LAST;
        else if (cycle_len == '0)  last = '0;
        else                       last = cycle_len - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || halt) begin
            cyc_cnt <= '0;
            slot    <= '0;
        end else if (cyc_cnt >= last) begin
            cyc_cnt <= '0;
            slot    <= slot + 1'b1;
        end else begin
            cyc_cnt <= cyc_cnt + 1'b1;
        end
    end

    assign cycle_start = (cyc_cnt == '0) && !halt;

endmodule

// File: rtl/stepdrv_seq.sv
module stepdrv_seq
    import stepdrv_pkg::*;
#(
    parameter int PW_W = 10
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 halt,
    input  logic                 cycle_start,
    input  logic [SLOT_W-1:0]    slot,
    input  batt_e                mode_in,
    input  logic [PW_W-1:0]      width_in,
    output logic                 active,
    output logic [CHOP_PH_W-1:0] phase,
    output logic                 pol,
    output batt_e                mode_q
);
    typedef struct packed {
        seq_e                   st;
        logic [PW_W-1:0]        cnt;
        logic [PW_W-1:0]        wid;
        logic [BURST_CNT_W-1:0] left;
        batt_e                  mode;
        logic                   pol;
    } seq_t;

    seq_t cur, nxt;

    always_comb begin
        nxt = cur;
        unique case (cur.st)
            SEQ_IDLE: begin
                if (cycle_start) begin
                    nxt.mode = mode_in;
                    nxt.wid  = (width_in == '0) ? PW_W'(1) : width_in;
                    nxt.cnt  = '0;
                    if (mode_in == BATT_EOL) begin
                        nxt.left = BURST_CNT_W'(BURST_LEN - 1);
                        if (slot == '0) nxt.st = SEQ_ON;
                    end else begin
                        nxt.left = '0;
                        nxt.st   = SEQ_ON;
                    end
                end
            end
            SEQ_ON: begin
                if (cur.cnt == cur.wid - 1'b1) begin
                    nxt.pol = ~cur.pol;
                    nxt.cnt = '0;
                    nxt.st  = (cur.left != '0) ? SEQ_GAP : SEQ_IDLE;
                end else begin
                    nxt.cnt = cur.cnt + 1'b1;
                end
            end
            SEQ_GAP: begin
                if (cur.cnt == cur.wid - 1'b1) begin
                    nxt.cnt  = '0;
                    nxt.left = cur.left - 1'b1;
                    nxt.st   = SEQ_ON;
                end else begin
                    nxt.cnt = cur.cnt + 1'b1;
                end
            end
            default: nxt.st = SEQ_IDLE;
        endcase
        if (halt) begin
            nxt.st  = SEQ_IDLE;
            nxt.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur.st   <= SEQ_IDLE;
            cur.cnt  <= '0;
            cur.wid  <= PW_W'(1);
            cur.left <= '0;
            cur.mode <= BATT_SILVER;
            cur.pol  <= 1'b0;
        end else begin
            cur <= nxt;
        end
    end

    assign active = (cur.st == SEQ_ON);
    assign phase  = cur.cnt[CHOP_PH_W-1:0];
    assign pol    = cur.pol;
    assign mode_q = cur.mode;

endmodule

// File: rtl/stepdrv_shaper.sv
module stepdrv_shaper
    import stepdrv_pkg::*;
(
    input  logic                 halt,
    input  logic                 active,
    input  logic [CHOP_PH_W-1:0] phase,
    input  logic                 pol,
    input  batt_e                mode,
    output drive_t               drv
);
    logic fire;

    always_comb begin
        fire   = active && !halt && chop_gate(mode, phase);
        drv.en = !halt;
        drv.m1 = fire && !pol;
        drv.m2 = fire && pol;
    end

endmodule

// File: rtl/stepper_pulse_gen.sv
module stepper_pulse_gen
    import stepdrv_pkg::*;
#(
    parameter int PW_W     = 10,
    parameter int CYC_W    = 18,
    parameter int FAST_CYC = 1024
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             stop_i,
    input  logic             fast_i,
    input  logic [1:0]       batt_mode_i,
    input  logic [PW_W-1:0]  pulse_width_i,
    input  logic [CYC_W-1:0] cycle_len_i,
    output logic             drv_en_o,
    output logic             m1_o,
    output logic             m2_o
);
    logic                 cyc_start;
    logic [SLOT_W-1:0]    slot;
    logic                 seq_active;
    logic [CHOP_PH_W-1:0] seq_phase;
    logic                 seq_pol;
    batt_e                seq_mode;
    drive_t               drv;

    stepdrv_timer #(
        .CYC_W    (CYC_W),
        .FAST_CYC (FAST_CYC),
        .SLOT_W   (SLOT_W)
    ) u_timer (
        .clk         (clk),
        .rst         (rst),
        .halt        (stop_i),
        .fast        (fast_i),
        .cycle_len   (cycle_len_i),
        .slot        (slot),
        .cycle_start (cyc_start)
    );

    stepdrv_seq #(
        .PW_W (PW_W)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .halt        (stop_i),
        .cycle_start (cyc_start),
        .slot        (slot),
        .mode_in     (batt_e'(batt_mode_i)),
        .width_in    (pulse_width_i),
        .active      (seq_active),
        .phase       (seq_phase),
        .pol         (seq_pol),
        .mode_q      (seq_mode)
    );

    stepdrv_shaper u_shaper (
        .halt   (stop_i),
        .active (seq_active),
        .phase  (seq_phase),
        .pol    (seq_pol),
        .mode   (seq_mode),
        .drv    (drv)
    );

    assign drv_en_o = drv.en;
    assign m1_o     = drv.m1;
    assign m2_o     = drv.m2;

endmodule

// File: rtl/stepdrv_chk.sv
module stepdrv_chk #(
    parameter int SLOT_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              stop_i,
    input logic [1:0]        batt_mode_i,
    input logic              drv_en_o,
    input logic              m1_o,
    input logic              m2_o,
    input logic              cyc_start,
    input logic [SLOT_W-1:0] slot,
    input logic              seq_active,
    input logic [1:0]        seq_mode
);
    // R10: coils never driven high together
    p_coil_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(m1_o && m2_o));

    // R7: halt releases the coils
    p_stop_hiz_r7: assert property (@(posedge clk) disable iff (rst)
        stop_i |-> (!drv_en_o && !m1_o && !m2_o));

    // R3: a non-burst cycle start is followed by a driven pulse
    p_start_r3: assert property (@(posedge clk) disable iff (rst)
        (cyc_start && batt_mode_i != 2'd2) |=> (stop_i || m1_o || m2_o));

    // R6: end-of-life cycles off the burst slot stay quiet
    p_eol_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (cyc_start && batt_mode_i == 2'd2 && slot != '0) |=> (!m1_o && !m2_o));

    // R4: a drive dip inside an active pulse only happens when chopping
    p_chop_only_r4: assert property (@(posedge clk) disable iff (rst)
        (seq_active && !stop_i && !m1_o && !m2_o) |-> (seq_mode == 2'd0));

endmodule

bind stepper_pulse_gen stepdrv_chk #(
    .SLOT_W (stepdrv_pkg::SLOT_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .stop_i      (stop_i),
    .batt_mode_i (batt_mode_i),
    .drv_en_o    (drv_en_o),
    .m1_o        (m1_o),
    .m2_o        (m2_o),
    .cyc_start   (cyc_start),
    .slot        (slot),
    .seq_active  (seq_active),
    .seq_mode    (seq_mode)
);

// File: tb/stepper_pulse_gen_tb.sv
module stepper_pulse_gen_tb;
    localparam int PW_W     = 10;
    localparam int CYC_W    = 18;
    localparam int FAST_CYC = 1024;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic             rst   = 1'b1;
    logic             stop  = 1'b0;
    logic             fast  = 1'b0;
    logic [1:0]       bmode = 2'd0;
    logic [PW_W-1:0]  pw    = 10'd20;
    logic [CYC_W-1:0] clen  = 18'd200;
    logic             drv_en_o, m1_o, m2_o;

    stepper_pulse_gen #(.PW_W(PW_W), .CYC_W(CYC_W), .FAST_CYC(FAST_CYC)) u_dut (
        .clk           (clk),
        .rst           (rst),
        .stop_i        (stop),
        .fast_i        (fast),
        .batt_mode_i   (bmode),
        .pulse_width_i (pw),
        .cycle_len_i   (clen),
        .drv_en_o      (drv_en_o),
        .m1_o          (m1_o),
        .m2_o          (m2_o)
    );

    int    checks = 0;
    int    fails  = 0;
    string tag    = "R1";

    // Behavioural reference: position in cycle and a plan of on-intervals.
    int   t = 0, slot = 0, pcount = 0;
    int   plan_n = 0, plan_w = 1, plan_mode = 0, plan_base = 0;
    int   per, st;
    logic exp_m1 = 1'b0, exp_m2 = 1'b0, exp_en = 1'b1;
    logic on_b;

    always @(posedge clk) begin
        exp_m1 = 1'b0;
        exp_m2 = 1'b0;
        if (rst) begin
            t = 0; slot = 0; plan_n = 0; pcount = 0;
        end else if (stop) begin
            t = 0; slot = 0; plan_n = 0;
        end else begin
            if (t == 0) begin
                plan_w    = (pw == 0) ? 1 : int'(pw);
                plan_mode = int'(bmode);
                plan_base = pcount;
                if (plan_mode == 2) plan_n = (slot % 4 == 0) ? 4 : 0;
                else                plan_n = 1;
            end
            for (int i = 0; i < plan_n; i++) begin
                st = 2 * i * plan_w;
                if (t == st + plan_w) pcount++;
                if (t >= st && t < st + plan_w) begin
                    on_b = (plan_mode != 0) || (((t - st) % 8) < 6);
                    if (((plan_base + i) % 2) == 0) exp_m1 = on_b;
                    else                            exp_m2 = on_b;
                end
            end
            per = fast ? FAST_CYC : int'(clen);
            if (t >= per - 1) begin
                t = 0;
                slot = (slot + 1) % 4;
            end else begin
                t++;
            end
        end
        exp_en = !stop;
        #2;
        checks++;
        if (m1_o !== exp_m1 || m2_o !== exp_m2 || drv_en_o !== exp_en) begin
            fails++;
            $display("FAIL %s: en/m1/m2 actual %b%b%b expected %b%b%b at %0t",
                     tag, drv_en_o, m1_o, m2_o, exp_en, exp_m1, exp_m2, $time);
        end
        checks++;
        if (m1_o === 1'b1 && m2_o === 1'b1) begin
            fails++;
            $display("FAIL R10: m1/m2 actual 11 expected not both high at %0t", $time);
        end
    end

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_t(input int v);
        do @(negedge clk); while (t != v);
    endtask

    initial begin
        #(400000 * 8);
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        // R1: reset state, then first pulse on m1
        run(4);
        rst = 1'b0;
        run(200);
        // R2 R3 R4: lithium chopping, alternating polarity
        tag = "R2 R3 R4";
        run(600);
        // R9: mode and width changed mid-pulse apply to next cycle only
        tag = "R9";
        wait_t(5);  bmode = 2'd1;
        wait_t(8);  pw = 10'd35;
        run(600);
        // R5: spare code behaves as solid
        tag = "R5";
        bmode = 2'd3;
        run(400);
        // R6: end-of-life bursts
        tag = "R6";
        bmode = 2'd2; pw = 10'd10;
        run(1800);
        // R7: halt in idle gap, then halt mid-pulse
        tag = "R7";
        wait_t(100); stop = 1'b1;
        run(40);     stop = 1'b0;
        run(600);
        wait_t(150); bmode = 2'd1;
        wait_t(3);   stop = 1'b1;
        run(10);     stop = 1'b0;
        run(500);
        // R8: fast test cycle overrides cycle length
        tag = "R8";
        wait_t(150);
        bmode = 2'd0; pw = 10'd30; clen = 18'd5000; fast = 1'b1;
        run(3500);
        // R3: new cycle length, width 0 treated as 1
        tag = "R3";
        wait_t(100);
        fast = 1'b0; clen = 18'd300; bmode = 2'd1;
        run(700);
        pw = 10'd0;
        run(700);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule